// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Feedback Divider

This block is the programmable feedback divider of a phase-locked loop, written as a digital model. It divides a fast input clock by N = B·P + A. A prescaler counts either P or P+1 input cycles per output tick. A swallow counter keeps the prescaler at P+1 for the first A ticks of each output period. A main counter ends the period after B ticks in total. At the end of every N-cycle period the block emits one pulse that is a single input cycle wide. The user picks the prescaler base P from four values, so that the prescaler tick rate can stay inside the rate the counters can handle.

Settings arrive with a load strobe. A load is held as pending and takes effect only at the next period boundary, so no period is ever cut short. A load made in the boundary cycle itself applies at that boundary. Settings that the structure cannot realise force an error state. In that state the divider stops, and it restarts as soon as a legal setting is loaded.

Top module: `pulse_swallow_divider`

## Requirements
- R1: The spacing between consecutive `div_pulse` assertions equals B·P + A input cycles for the active setting.
- R2: The prescaler base is selected by `psel`: code 0 gives P = 8, 1 gives 16, 2 gives 32 and 3 gives 64, each paired with P+1.
- R3: Within each period `mod_hi` is high for the first A prescaler ticks, which is A·(P+1) input cycles. It stays low for the remaining B−A ticks and does not rise again before the period ends.
- R4: `div_pulse` is exactly one input cycle wide.
- R5: A load made in any cycle other than the last cycle of a period does not change the period in progress. The new setting governs from the following period.
- R6: A load that coincides with the last cycle of a period is applied at that same boundary. The pulse still appears on time, and the next period uses the new setting.
- R7: Adopting a setting with B < 3 or B < A sets `cfg_err`. While `cfg_err` is high, no `div_pulse` occurs and `mod_hi` stays low. A further illegal load keeps `cfg_err` set.
- R8: While `cfg_err` is high, a load with a legal setting is adopted at the next clock edge and clears `cfg_err`. The first pulse then follows N cycles after that edge, and later pulses are N apart.
- R9: After reset the outputs are low and the active setting is P = 8, A = 0, B = 3, giving a 24-cycle period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | High-speed input clock being divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| load | input | 1 | Strobe that captures `psel`, `a_val` and `b_val` |
| psel | input | 2 | Prescaler base select (0:8, 1:16, 2:32, 3:64) |
| a_val | input | 6 | Swallow count A |
| b_val | input | 12 | Main count B |
| div_pulse | output | 1 | One-cycle pulse at the end of each period |
| mod_hi | output | 1 | High while the prescaler divides by P+1 |
| cfg_err | output | 1 | Active setting is illegal; divider halted |

## Verification
The load strobe and the period boundary can land in the same input cycle. In that case the update bypasses the pending register and takes effect at once. The bench provokes this by counting N−1 cycles from a pulse and then raising `load`, so that the strobe is sampled on the very edge that ends the period. The result is judged at two points: the pulse must still arrive after the old N, and the very next interval must already equal the new N. A mid-period load is timed against the same boundary and must leave the current interval untouched.

// File: rtl/psd_pkg.sv
package psd_pkg;

  // Smallest prescaler base is 2**PMIN_LOG2
  localparam int unsigned PMIN_LOG2 = 3;

  typedef enum logic [1:0] {
    PSC_8  = 2'd0,
    PSC_16 = 2'd1,
    PSC_32 = 2'd2,
    PSC_64 = 2'd3
  } psc_sel_e;

  // Prescaler base P for a select code
  function automatic int unsigned modulus_of(input int unsigned sel);
    return 32'd1 << (PMIN_LOG2 + sel);
  endfunction

  // Total division ratio for a setting
  function automatic int unsigned ratio_of(input int unsigned sel,
                                           input int unsigned a,
                                           input int unsigned b);
    return b * modulus_of(sel) + a;
  endfunction

  // Legality of a setting: swallow fits, and the main count is large enough
  function automatic logic setting_ok(input int unsigned a,
                                      input int unsigned b,
                                      input int unsigned min_b);
    return (b >= a) && (b >= min_b);
  endfunction

endpackage

// File: rtl/psd_cfg_stage.sv
module psd_cfg_stage
  import psd_pkg::*;
#(
  parameter int unsigned A_W     = 6,
  parameter int unsigned B_W     = 12,
  parameter int unsigned SEL_W   = 2,
  parameter int unsigned MIN_B   = 3,
  parameter int unsigned RST_A   = 0,
  parameter int unsigned RST_B   = 3,
  parameter int unsigned RST_SEL = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [A_W-1:0]   a_i,
  input  logic [B_W-1:0]   b_i,
  input  logic             period_end_i,
  output logic [SEL_W-1:0] act_sel_o,
  output logic [A_W-1:0]   act_a_o,
  output logic [B_W-1:0]   act_b_o,
  output logic             err_o,
  output logic             adopt_o
);

  logic             pend_v;
  logic [SEL_W-1:0] pend_sel;
  logic [A_W-1:0]   pend_a;
  logic [B_W-1:0]   pend_b;

  logic [SEL_W-1:0] eff_sel;
  logic [A_W-1:0]   eff_a;
  logic [B_W-1:0]   eff_b;
  logic             eff_ok;
  logic             at_boundary;
  logic             from_halt;

  // A strobe in the adoption cycle bypasses the pending copy
  assign eff_sel = load_i ? sel_i : pend_sel;
  assign eff_a   = load_i ? a_i   : pend_a;
  assign eff_b   = load_i ? b_i   : pend_b;
  assign eff_ok  = setting_ok(32'(eff_a), 32'(eff_b), MIN_B);

  assign at_boundary = period_end_i && (load_i || pend_v);
  assign from_halt   = err_o && load_i;
  assign adopt_o     = at_boundary || from_halt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_v    <= 1'b0;
      pend_sel  <= SEL_W'(RST_SEL);
      pend_a    <= A_W'(RST_A);
      pend_b    <= B_W'(RST_B);
      act_sel_o <= SEL_W'(RST_SEL);
      act_a_o   <= A_W'(RST_A);
      act_b_o   <= B_W'(RST_B);
      err_o     <= 1'b0;
    end else if (adopt_o) begin
      act_sel_o <= eff_sel;
      act_a_o   <= eff_a;
      act_b_o   <= eff_b;
      err_o     <= !eff_ok;
      pend_v    <= 1'b0;
    end else if (load_i) begin
      pend_sel  <= sel_i;
      pend_a    <= a_i;
      pend_b    <= b_i;
      pend_v    <= 1'b1;
    end
  end

endmodule

// File: rtl/psd_prescaler.sv
module psd_prescaler
  import psd_pkg::*;
#(
  parameter int unsigned SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             clr_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             swallow_i,
  output logic             tick_o
);

  localparam int unsigned NSEL = 1 << SEL_W;
  // Largest modulus is 2**(PMIN_LOG2+NSEL-1)+1
  localparam int unsigned PC_W = PMIN_LOG2 + NSEL;

  logic [PC_W-1:0] base_tbl [NSEL];
  logic [PC_W-1:0] base;
  logic [PC_W-1:0] term;
  logic [PC_W-1:0] cnt;

  for (genvar k = 0; k < NSEL; k++) begin : g_base
    assign base_tbl[k] = PC_W'(modulus_of(unsigned'(k)));
  end

  assign base   = base_tbl[sel_i];
  // P+1 cycles end at count P, P cycles end at count P-1
  assign term   = swallow_i ? base : base - PC_W'(1);
  assign tick_o = run_i && (cnt == term);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (clr_i)  cnt <= '0;
    else if (run_i)  cnt <= tick_o ? '0 : cnt + PC_W'(1);
  end

endmodule

// File: rtl/psd_swallow_ctr.sv
module psd_swallow_ctr #(
  parameter int unsigned A_W = 6,
  parameter int unsigned B_W = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run_i,
  input  logic           clr_i,
  input  logic           tick_i,
  input  logic [A_W-1:0] act_a_i,
  input  logic [B_W-1:0] act_b_i,
  output logic           swallow_o,
  output logic           last_o
);

  logic [A_W-1:0] a_idx;
  logic [B_W-1:0] b_idx;

  assign swallow_o = run_i && (a_idx < act_a_i);
  assign last_o    = tick_i && (b_idx == act_b_i - B_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_idx <= '0;
      b_idx <= '0;
    end else if (clr_i) begin
      a_idx <= '0;
      b_idx <= '0;
    end else if (tick_i) begin
      b_idx <= b_idx + B_W'(1);
      if (swallow_o) a_idx <= a_idx + A_W'(1);
    end
  end

endmodule

// File: rtl/pulse_swallow_divider.sv
module pulse_swallow_divider
  import psd_pkg::*;
#(
  parameter int unsigned A_W     = 6,
  parameter int unsigned B_W     = 12,
  parameter int unsigned SEL_W   = 2,
  parameter int unsigned MIN_B   = 3,
  parameter int unsigned RST_A   = 0,
  parameter int unsigned RST_B   = 3,
  parameter int unsigned RST_SEL = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [SEL_W-1:0] psel,
  input  logic [A_W-1:0]   a_val,
  input  logic [B_W-1:0]   b_val,
  output logic             div_pulse,
  output logic             mod_hi,
  output logic             cfg_err
);

  logic [SEL_W-1:0] act_sel;
  logic [A_W-1:0]   act_a;
  logic [B_W-1:0]   act_b;
  logic             adopt;
  logic             run;
  logic             clr;
  logic             swallow;
  logic             prescale_tick;
  logic             b_last;
  logic             period_end;

  psd_cfg_stage #(
    .A_W(A_W), .B_W(B_W), .SEL_W(SEL_W), .MIN_B(MIN_B),
    .RST_A(RST_A), .RST_B(RST_B), .RST_SEL(RST_SEL)
  ) u_cfg (
    .clk          (clk),
    .rst_n        (rst_n),
    .load_i       (load),
    .sel_i        (psel),
    .a_i          (a_val),
    .b_i          (b_val),
    .period_end_i (period_end),
    .act_sel_o    (act_sel),
    .act_a_o      (act_a),
    .act_b_o      (act_b),
    .err_o        (cfg_err),
    .adopt_o      (adopt)
  );

  assign run        = !cfg_err;
  assign period_end = b_last && run;
  assign clr        = period_end || cfg_err;

  psd_prescaler #(.SEL_W(SEL_W)) u_psc (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_i     (run),
    .clr_i     (clr),
    .sel_i     (act_sel),
    .swallow_i (swallow),
    .tick_o    (prescale_tick)
  );

  psd_swallow_ctr #(.A_W(A_W), .B_W(B_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_i     (run),
    .clr_i     (clr),
    .tick_i    (prescale_tick),
    .act_a_i   (act_a),
    .act_b_i   (act_b),
    .swallow_o (swallow),
    .last_o    (b_last)
  );

  assign mod_hi = swallow;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_pulse <= 1'b0;
    else        div_pulse <= period_end;
  end

endmodule

// File: rtl/psd_checker.sv
module psd_checker
  import psd_pkg::*;
#(
  parameter int unsigned A_W   = 6,
  parameter int unsigned B_W   = 12,
  parameter int unsigned SEL_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             div_pulse,
  input logic             mod_hi,
  input logic             cfg_err,
  input logic             period_end,
  input logic [SEL_W-1:0] act_sel,
  input logic [A_W-1:0]   act_a,
  input logic [B_W-1:0]   act_b
);

  // Cycles elapsed in the running period, first cycle counted as 1
  logic [31:0] gap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     gap <= 32'd1;
    else if (period_end || cfg_err) gap <= 32'd1;
    else                            gap <= gap + 32'd1;
  end

  AST_PERIOD_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    period_end |-> (gap == ratio_of(32'(act_sel), 32'(act_a), 32'(act_b)))); // R1

  AST_SWALLOW_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (!mod_hi && !period_end && !cfg_err) |=> !mod_hi); // R3

  AST_PULSE_ONE_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
    div_pulse |=> !div_pulse); // R4

  AST_CFG_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    (!period_end && !cfg_err) |=> ($stable(act_sel) && $stable(act_a) && $stable(act_b))); // R5

  AST_ERR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> !div_pulse); // R7

  AST_ERR_NO_SWALLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !mod_hi); // R7

endmodule

bind pulse_swallow_divider psd_checker #(
  .A_W(A_W), .B_W(B_W), .SEL_W(SEL_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .div_pulse  (div_pulse),
  .mod_hi     (mod_hi),
  .cfg_err    (cfg_err),
  .period_end (period_end),
  .act_sel    (act_sel),
  .act_a      (act_a),
  .act_b      (act_b)
);

// File: tb/pulse_swallow_divider_tb.sv
module pulse_swallow_divider_tb;

  logic        clk   = 1'b0;
  logic        rst_n = 1'b0;
  logic        load  = 1'b0;
  logic [1:0]  psel  = 2'd0;
  logic [5:0]  a_val = 6'd0;
  logic [11:0] b_val = 12'd0;
  logic        div_pulse;
  logic        mod_hi;
  logic        cfg_err;

  int n_checks = 0;
  int n_fail   = 0;
  int cur_n    = 0;
  bit wide_seen = 1'b0;
  bit done      = 1'b0;

  always #10 clk = ~clk;

  pulse_swallow_divider u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .psel      (psel),
    .a_val     (a_val),
    .b_val     (b_val),
    .div_pulse (div_pulse),
    .mod_hi    (mod_hi),
    .cfg_err   (cfg_err)
  );

  // Bench view of the ratio: B periods of P plus one extra cycle per swallow
  function automatic int exp_ratio(input int sel, input int a, input int b);
    int p;
    p = 8;
    for (int i = 0; i < sel; i++) p = p * 2;
    return (b - a) * p + a * (p + 1);
  endfunction

  function automatic int exp_hi_cycles(input int sel, input int a);
    return a * (exp_ratio(sel, 0, 1) + 1);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  // Counts cycles up to the next pulse; hi counts mod_hi over one period window
  task automatic wait_pulse(output int cyc, output int hi);
    cyc = 0;
    hi  = int'(mod_hi);
    do begin
      @(negedge clk); #1;
      load = 1'b0;
      cyc++;
      if (cyc == 1 && div_pulse) wide_seen = 1'b1;
      if (!div_pulse) hi += int'(mod_hi);
    end while (!div_pulse && cyc < 40000);
  endtask

  // Mid-period load, called in a pulse cycle
  task automatic do_step(input int sel, input int a, input int b, input string req);
    int c, h, n;
    psel = 2'(sel); a_val = 6'(a); b_val = 12'(b); load = 1'b1;
    wait_pulse(c, h);
    check(c == cur_n, "R5", "period in progress after load", c, cur_n);
    n = exp_ratio(sel, a, b);
    wait_pulse(c, h);
    check(c == n, req, "interval for new setting", c, n);
    check(h == exp_hi_cycles(sel, a), "R3", "cycles at P+1", h, exp_hi_cycles(sel, a));
    cur_n = n;
  endtask

  // Load timed onto the last cycle of the period, called in a pulse cycle
  task automatic boundary_step(input int sel, input int a, input int b);
    int c, h, n;
    for (int i = 0; i < cur_n - 1; i++) begin
      @(negedge clk); #1;
    end
    psel = 2'(sel); a_val = 6'(a); b_val = 12'(b); load = 1'b1;
    @(negedge clk); #1;
    load = 1'b0;
    check(div_pulse == 1'b1, "R6", "pulse on time at coinciding load", int'(div_pulse), 1);
    n = exp_ratio(sel, a, b);
    wait_pulse(c, h);
    check(c == n, "R6", "next interval uses coinciding load", c, n);
    cur_n = n;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int c, h, pc, hc, n;
    int unsigned seed;
    seed = 32'h1F2E3D4C;
    void'($urandom(seed));

    // R9: reset state
    repeat (3) @(negedge clk);
    #1;
    check(div_pulse == 1'b0, "R9", "div_pulse in reset", int'(div_pulse), 0);
    check(cfg_err == 1'b0, "R9", "cfg_err in reset", int'(cfg_err), 0);
    check(mod_hi == 1'b0, "R9", "mod_hi in reset", int'(mod_hi), 0);
    rst_n = 1'b1;
    wait_pulse(c, h);
    wait_pulse(c, h);
    check(c == 24, "R9", "default period", c, 24);
    cur_n = 24;

    // R1: directed ratios
    do_step(1, 12, 168, "R1");
    do_step(2, 20, 140, "R1");
    do_step(2, 14, 273, "R1");
    do_step(2, 8, 306, "R1");

    // R3 corners: A equal to B, A zero, widest A, smallest B
    do_step(0, 20, 20, "R1");
    do_step(2, 0, 3, "R1");
    do_step(3, 63, 63, "R1");
    do_step(3, 3, 3, "R1");

    // R2: random settings over every prescaler code
    for (int k = 0; k < 8; k++) begin
      int rs, rb, ra;
      rs = int'($urandom % 4);
      rb = 3 + int'($urandom % 28);
      ra = int'($urandom % unsigned'(rb + 1));
      do_step(rs, ra, rb, "R2");
      if (k == 3) boundary_step(1, 5, 9);
    end

    // R6: coinciding load with a directed setting
    boundary_step(0, 7, 11);

    // R7: illegal main count, adopted at the boundary
    psel = 2'd0; a_val = 6'd0; b_val = 12'd2; load = 1'b1;
    wait_pulse(c, h);
    check(c == cur_n, "R5", "period in progress before error", c, cur_n);
    check(cfg_err == 1'b1, "R7", "cfg_err after B<3", int'(cfg_err), 1);
    pc = 0; hc = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk); #1;
      if (div_pulse) pc++;
      if (mod_hi) hc++;
    end
    check(pc == 0, "R7", "pulses while halted", pc, 0);
    check(hc == 0, "R7", "mod_hi cycles while halted", hc, 0);

    // R7: A above B while halted
    psel = 2'd1; a_val = 6'd9; b_val = 12'd5; load = 1'b1;
    @(negedge clk); #1;
    load = 1'b0;
    @(negedge clk); #1;
    check(cfg_err == 1'b1, "R7", "cfg_err after B<A", int'(cfg_err), 1);

    // R8: legal load restarts the divider
    psel = 2'd1; a_val = 6'd3; b_val = 12'd4; load = 1'b1;
    @(negedge clk); #1;
    load = 1'b0;
    check(cfg_err == 1'b0, "R8", "cfg_err cleared by legal load", int'(cfg_err), 0);
    n = exp_ratio(1, 3, 4);
    wait_pulse(c, h);
    check(c == n, "R8", "first pulse after restart", c, n);
    wait_pulse(c, h);
    check(c == n, "R8", "interval after restart", c, n);
    cur_n = n;

    // R4: no pulse ever lasted two cycles
    check(!wide_seen, "R4", "pulse width over 1 cycle seen", int'(wide_seen), 0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule